// File: doc/BRIEF.md
# Paged Packet Buffer Allocator

This block hands out and takes back space in a packet memory divided into 256-byte pages. Software and the receive path share one command port. A command can request a run of 1 to 7 contiguous pages, return the pages of a given packet, drop the packet at the front of the receive queue, place a packet on the transmit queue, or reset the whole allocator. A packet is named by the index of its first page, which is always a 7-bit number.

An allocation is settled in the cycle the command is presented. The lowest-indexed run of free pages that is long enough is taken. The outcome appears on a result byte one clock later: bit 7 low with the packet number in bits 6:0 on success, or exactly 0x80 when nothing was granted. A successful grant also raises an allocation interrupt bit. Three first-in first-out queues of packet numbers connect the allocator to the MAC side: packets waiting to transmit, packets whose transmission has finished, and received packets. The finished and received queues each show an empty flag and their oldest entry.

Top module: `pbuf_alloc`

## Requirements
- R1: An allocate command (cmd_op=1) with page count cmd_arg[3:0] in 1..7 takes the lowest-indexed run of that many free pages. From the next cycle, alloc_result holds bit 7 = 0 and bits 6:0 = the index of the run's first page, and those pages are marked in use.
- R2: An allocate command with a count of 0, a count above 7, or no free run long enough sets alloc_result to 8'h80, takes no pages and does not set irq_status[0].
- R3: A successful allocation sets irq_status[0] on the next cycle. The bit holds until a cycle with irq_ack[0]=1 and no new grant clears it. A grant in the same cycle as the acknowledge leaves the bit set.
- R4: A free command (cmd_op=4) whose cmd_arg is the first page of an allocated packet returns all of that packet's pages to the free pool. A free of any other number changes nothing.
- R5: A reset command (cmd_op=2) marks every page free, sets alloc_result to 8'h80, clears both irq_status bits and empties all three queues, all visible on the next cycle. The same state holds after rst_n is released.
- R6: rx_push appends rx_push_pnum to the receive queue. rx_empty is 1 exactly when the queue holds no entry, and rx_head_pnum shows the oldest entry.
- R7: A release command (cmd_op=3) frees the pages of the packet at the head of the receive queue and removes that entry. With the receive queue empty, a release changes nothing.
- R8: An enqueue command (cmd_op=5) appends cmd_arg to the transmit queue. tx_req_valid and tx_req_pnum present the oldest entry, and tx_take removes it.
- R9: tx_complete appends tx_complete_pnum to the finished queue and sets irq_status[1]. txd_empty and the 7-bit txd_pnum show that queue's state and oldest entry, txd_pop removes the entry, and irq_ack[1] clears irq_status[1].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one command per cycle |
| cmd_op | input | 3 | 1 allocate, 2 reset, 3 release head, 4 free packet, 5 enqueue |
| cmd_arg | input | 7 | Page count (bits 3:0) or packet number |
| alloc_result | output | 8 | Bit 7 failure, bits 6:0 granted packet number |
| irq_status | output | 2 | Bit 0 allocation done, bit 1 transmit done |
| irq_ack | input | 2 | Write-one-to-clear for irq_status |
| tx_req_valid | output | 1 | Transmit queue holds a packet |
| tx_req_pnum | output | 7 | Oldest packet waiting to transmit |
| tx_take | input | 1 | MAC removes the oldest transmit entry |
| tx_complete | input | 1 | MAC finished a transmission |
| tx_complete_pnum | input | 7 | Number of the finished packet |
| txd_empty | output | 1 | Finished queue is empty |
| txd_pnum | output | 7 | Oldest finished packet number |
| txd_pop | input | 1 | Remove the oldest finished entry |
| rx_push | input | 1 | MAC stored a received packet |
| rx_push_pnum | input | 7 | Number of the received packet |
| rx_empty | output | 1 | Receive queue is empty |
| rx_head_pnum | output | 7 | Oldest received packet number |

## Verification
The allocator is driven first with a scripted series of allocate and free commands. The series fills memory exactly and then requests one page more. It also asks for counts of 0 and 8, asks for a run one page longer than the largest gap, frees a number from the middle of a packet, and refills a gap with a shorter request. These cases separate a true first-fit scan from one that ignores run length, and a real length table from a free that clears only one page. Directed sequences then cover release ordering against the receive queue, a release on an empty queue, acknowledge and grant in the same cycle, the order of both transmit queues, and a reset issued with every queue and interrupt bit occupied.

// File: rtl/pbuf_pkg.sv
package pbuf_pkg;

    localparam int PNUM_W = 7;
    localparam logic [7:0] RESULT_NONE = 8'h80;

    localparam int IRQ_ALLOC = 0;
    localparam int IRQ_TX    = 1;

    typedef enum logic [2:0] {
        OP_NOP     = 3'd0,
        OP_ALLOC   = 3'd1,
        OP_RESET   = 3'd2,
        OP_RELEASE = 3'd3,
        OP_FREE    = 3'd4,
        OP_ENQUEUE = 3'd5
    } pbuf_op_e;

endpackage

// File: rtl/pbuf_num_fifo.sv
module pbuf_num_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic         empty,
    output logic [W-1:0] head
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);
    localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           rd;
        logic [AW-1:0]           wr;
        logic [CW-1:0]           cnt;
    } fifo_t;

    fifo_t st_q, st_d;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == PTR_LAST) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        logic do_pop, do_push;
        st_d    = st_q;
        do_pop  = pop && (st_q.cnt != '0);
        do_push = push && ((st_q.cnt != CNT_FULL) || do_pop);
        if (do_push) begin
            st_d.mem[st_q.wr] = push_data;
            st_d.wr           = ptr_next(st_q.wr);
        end
        if (do_pop) begin
            st_d.rd = ptr_next(st_q.rd);
        end
        if (do_push && !do_pop) begin
            st_d.cnt = st_q.cnt + CW'(1);
        end else if (do_pop && !do_push) begin
            st_d.cnt = st_q.cnt - CW'(1);
        end
        if (clear) begin
            st_d.rd  = '0;
            st_d.wr  = '0;
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign empty = (st_q.cnt == '0);
    assign head  = st_q.mem[st_q.rd];

endmodule

// File: rtl/pbuf_page_map.sv
module pbuf_page_map #(
    parameter int NUM_PAGES = 16,
    parameter int MAX_RUN   = 7,
    parameter int CNT_W     = 4,
    parameter int PN_W      = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             alloc_req,
    input  logic [CNT_W-1:0] alloc_cnt,
    input  logic             free_req,
    input  logic [PN_W-1:0]  free_pnum,
    output logic             grant,
    output logic [PN_W-1:0]  grant_pnum
);
    localparam int LEN_W = $clog2(MAX_RUN + 1);
    localparam int IDX_W = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1;
    localparam logic [PN_W:0]  PN_LIMIT  = (PN_W + 1)'(NUM_PAGES);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_RUN);

    typedef struct packed {
        logic [NUM_PAGES-1:0]            used;
        logic [NUM_PAGES-1:0][LEN_W-1:0] len;
    } map_t;

    map_t st_q, st_d;

    logic             fit_found;
    logic [IDX_W-1:0] fit_start;
    logic [NUM_PAGES-1:0] want_mask;

    function automatic logic [NUM_PAGES-1:0] run_mask(input int n);
        logic [NUM_PAGES-1:0] m;
        for (int i = 0; i < NUM_PAGES; i++) begin
            m[i] = (i < n);
        end
        return m;
    endfunction

    // First-fit search: the lowest start index wins since it is visited last.
    always_comb begin
        want_mask = run_mask(int'(alloc_cnt));
        fit_found = 1'b0;
        fit_start = '0;
        for (int s = NUM_PAGES - 1; s >= 0; s--) begin
            if ((s + int'(alloc_cnt) <= NUM_PAGES) &&
                ((st_q.used & (want_mask << s)) == '0)) begin
                fit_found = 1'b1;
                fit_start = IDX_W'(s);
            end
        end
    end

    assign grant = alloc_req && (alloc_cnt != '0) && (alloc_cnt <= CNT_MAX) && fit_found;
    assign grant_pnum = PN_W'(fit_start);

    always_comb begin
        logic [IDX_W-1:0] fidx;
        logic [LEN_W-1:0] flen;
        st_d = st_q;
        fidx = IDX_W'(free_pnum);
        flen = st_q.len[fidx];
        if (free_req && ({1'b0, free_pnum} < PN_LIMIT)) begin
            st_d.used      = st_d.used & ~(run_mask(int'(flen)) << fidx);
            st_d.len[fidx] = '0;
        end
        if (grant) begin
            st_d.used           = st_d.used | (want_mask << fit_start);
            st_d.len[fit_start] = LEN_W'(alloc_cnt);
        end
        if (clear) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/pbuf_alloc.sv
module pbuf_alloc
    import pbuf_pkg::*;
#(
    parameter int NUM_PAGES = 16,
    parameter int MAX_RUN   = 7,
    parameter int CNT_W     = 4,
    parameter int Q_DEPTH   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [PNUM_W-1:0] cmd_arg,
    output logic [7:0]        alloc_result,
    output logic [1:0]        irq_status,
    input  logic [1:0]        irq_ack,
    output logic              tx_req_valid,
    output logic [PNUM_W-1:0] tx_req_pnum,
    input  logic              tx_take,
    input  logic              tx_complete,
    input  logic [PNUM_W-1:0] tx_complete_pnum,
    output logic              txd_empty,
    output logic [PNUM_W-1:0] txd_pnum,
    input  logic              txd_pop,
    input  logic              rx_push,
    input  logic [PNUM_W-1:0] rx_push_pnum,
    output logic              rx_empty,
    output logic [PNUM_W-1:0] rx_head_pnum
);
    typedef struct packed {
        logic [7:0] result;
        logic [1:0] irq;
    } top_t;

    top_t st_q, st_d;

    logic is_alloc, is_reset, is_release, is_free, is_enq;
    logic map_free, map_grant;
    logic [PNUM_W-1:0] map_free_pnum, map_grant_pnum;
    logic txq_empty, txd_head_empty, rxq_empty;
    logic [PNUM_W-1:0] txd_head;

    assign is_alloc   = cmd_valid && (cmd_op == OP_ALLOC);
    assign is_reset   = cmd_valid && (cmd_op == OP_RESET);
    assign is_release = cmd_valid && (cmd_op == OP_RELEASE) && !rxq_empty;
    assign is_free    = cmd_valid && (cmd_op == OP_FREE);
    assign is_enq     = cmd_valid && (cmd_op == OP_ENQUEUE);

    assign map_free      = is_free || is_release;
    assign map_free_pnum = is_release ? rx_head_pnum : cmd_arg;

    pbuf_page_map #(
        .NUM_PAGES (NUM_PAGES),
        .MAX_RUN   (MAX_RUN),
        .CNT_W     (CNT_W),
        .PN_W      (PNUM_W)
    ) u_map (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (is_reset),
        .alloc_req  (is_alloc),
        .alloc_cnt  (cmd_arg[CNT_W-1:0]),
        .free_req   (map_free),
        .free_pnum  (map_free_pnum),
        .grant      (map_grant),
        .grant_pnum (map_grant_pnum)
    );

    pbuf_num_fifo #(.DEPTH(Q_DEPTH), .W(PNUM_W)) u_txq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (is_reset),
        .push      (is_enq),
        .push_data (cmd_arg),
        .pop       (tx_take),
        .empty     (txq_empty),
        .head      (tx_req_pnum)
    );

    pbuf_num_fifo #(.DEPTH(Q_DEPTH), .W(PNUM_W)) u_txdq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (is_reset),
        .push      (tx_complete),
        .push_data (tx_complete_pnum),
        .pop       (txd_pop),
        .empty     (txd_head_empty),
        .head      (txd_head)
    );

    pbuf_num_fifo #(.DEPTH(Q_DEPTH), .W(PNUM_W)) u_rxq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (is_reset),
        .push      (rx_push),
        .push_data (rx_push_pnum),
        .pop       (is_release),
        .empty     (rxq_empty),
        .head      (rx_head_pnum)
    );

    always_comb begin
        st_d = st_q;
        st_d.irq = st_q.irq & ~irq_ack;
        if (is_alloc) begin
            if (map_grant) begin
                st_d.result         = {1'b0, map_grant_pnum};
                st_d.irq[IRQ_ALLOC] = 1'b1;
            end else begin
                st_d.result = RESULT_NONE;
            end
        end
        if (tx_complete) begin
            st_d.irq[IRQ_TX] = 1'b1;
        end
        if (is_reset) begin
            st_d.result = RESULT_NONE;
            st_d.irq    = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{result: RESULT_NONE, irq: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign alloc_result = st_q.result;
    assign irq_status   = st_q.irq;
    assign tx_req_valid = !txq_empty;
    assign txd_empty    = txd_head_empty;
    assign txd_pnum     = txd_head & 7'h7F;
    assign rx_empty     = rxq_empty;

endmodule

// File: rtl/pbuf_alloc_chk.sv
module pbuf_alloc_chk
    import pbuf_pkg::*;
#(
    parameter int MAX_RUN = 7,
    parameter int CNT_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [2:0]        cmd_op,
    input logic [PNUM_W-1:0] cmd_arg,
    input logic [7:0]        alloc_result,
    input logic [1:0]        irq_status,
    input logic              tx_complete,
    input logic              txd_empty,
    input logic              rx_empty,
    input logic              rx_push
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_RUN);

    logic bad_count;
    assign bad_count = (cmd_arg[CNT_W-1:0] == '0) || (cmd_arg[CNT_W-1:0] > CNT_MAX);

    AST_BAD_COUNT_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_ALLOC && bad_count) |=> (alloc_result == RESULT_NONE)); // R2

    AST_FAIL_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_result[7] |-> (alloc_result[6:0] == '0)); // R1

    AST_IRQ_ON_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_status[IRQ_ALLOC]) |-> !alloc_result[7]); // R3

    AST_RESET_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_RESET) |=>
        (alloc_result == RESULT_NONE && irq_status == 2'b00 && rx_empty && txd_empty)); // R5

    AST_RELEASE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_RELEASE && rx_empty && !rx_push) |=> rx_empty); // R7

    AST_TX_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_complete && !(cmd_valid && cmd_op == OP_RESET)) |=>
        (irq_status[IRQ_TX] && !txd_empty)); // R9

endmodule

bind pbuf_alloc pbuf_alloc_chk #(.MAX_RUN(MAX_RUN), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_op       (cmd_op),
    .cmd_arg      (cmd_arg),
    .alloc_result (alloc_result),
    .irq_status   (irq_status),
    .tx_complete  (tx_complete),
    .txd_empty    (txd_empty),
    .rx_empty     (rx_empty),
    .rx_push      (rx_push)
);

// File: tb/pbuf_alloc_test.sv
`timescale 1ns/1ps
module pbuf_alloc_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [6:0] cmd_arg = 7'd0;
    logic [7:0] alloc_result;
    logic [1:0] irq_status;
    logic [1:0] irq_ack = 2'b00;
    logic       tx_req_valid;
    logic [6:0] tx_req_pnum;
    logic       tx_take = 1'b0;
    logic       tx_complete = 1'b0;
    logic [6:0] tx_complete_pnum = 7'd0;
    logic       txd_empty;
    logic [6:0] txd_pnum;
    logic       txd_pop = 1'b0;
    logic       rx_push = 1'b0;
    logic [6:0] rx_push_pnum = 7'd0;
    logic       rx_empty;
    logic [6:0] rx_head_pnum;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pbuf_alloc uut (.*);

    // {op[2:0], arg[6:0], expected result[7:0], expected alloc irq}
    localparam int NV = 15;
    localparam logic [18:0] VEC [NV] = '{
        {3'd1, 7'd3, 8'h00, 1'b1},
        {3'd1, 7'd7, 8'h03, 1'b1},
        {3'd1, 7'd8, 8'h80, 1'b0},
        {3'd1, 7'd0, 8'h80, 1'b0},
        {3'd1, 7'd7, 8'h80, 1'b0},
        {3'd1, 7'd6, 8'h0A, 1'b1},
        {3'd1, 7'd1, 8'h80, 1'b0},
        {3'd4, 7'd3, 8'h80, 1'b0},
        {3'd1, 7'd2, 8'h03, 1'b1},
        {3'd1, 7'd5, 8'h05, 1'b1},
        {3'd4, 7'd4, 8'h05, 1'b0},
        {3'd1, 7'd1, 8'h80, 1'b0},
        {3'd4, 7'd0, 8'h80, 1'b0},
        {3'd1, 7'd4, 8'h80, 1'b0},
        {3'd1, 7'd3, 8'h00, 1'b1}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_cmd(input logic [2:0] op, input logic [6:0] arg);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_arg = arg;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd0; cmd_arg = 7'd0;
    endtask

    task automatic ack(input logic [1:0] m);
        @(negedge clk); irq_ack = m;
        @(negedge clk); irq_ack = 2'b00;
    endtask

    task automatic rx_in(input logic [6:0] p);
        @(negedge clk); rx_push = 1'b1; rx_push_pnum = p;
        @(negedge clk); rx_push = 1'b0;
    endtask

    task automatic tx_done(input logic [6:0] p);
        @(negedge clk); tx_complete = 1'b1; tx_complete_pnum = p;
        @(negedge clk); tx_complete = 1'b0;
    endtask

    task automatic take_pulse();
        @(negedge clk); tx_take = 1'b1;
        @(negedge clk); tx_take = 1'b0;
    endtask

    task automatic txd_pop_pulse();
        @(negedge clk); txd_pop = 1'b1;
        @(negedge clk); txd_pop = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R5: state after reset release
        check("R5 reset result", alloc_result, 8'h80);
        check("R5 reset irq", irq_status, 2'b00);
        check("R5 reset rx_empty", rx_empty, 1'b1);
        check("R5 reset txd_empty", txd_empty, 1'b1);
        check("R5 reset tx_req_valid", tx_req_valid, 1'b0);

        // R1 R2 R4: scripted first-fit / free sequence
        for (int i = 0; i < NV; i++) begin
            do_cmd(VEC[i][18:16], VEC[i][15:9]);
            check($sformatf("R1/R2/R4 vec%0d result", i), alloc_result, VEC[i][8:1]);
            check($sformatf("R3 vec%0d irq", i), irq_status[0], VEC[i][0]);
            ack(2'b01);
        end

        // R3: grant and acknowledge in the same cycle, then hold, then clear
        do_cmd(3'd2, 7'd0);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd1; cmd_arg = 7'd1; irq_ack = 2'b01;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd0; cmd_arg = 7'd0; irq_ack = 2'b00;
        check("R3 set beats ack", irq_status[0], 1'b1);
        check("R1 after reset", alloc_result, 8'h00);
        repeat (3) @(negedge clk);
        check("R3 hold", irq_status[0], 1'b1);
        ack(2'b01);
        check("R3 ack clears", irq_status[0], 1'b0);

        // R6 R7: receive queue and release
        do_cmd(3'd2, 7'd0);
        do_cmd(3'd1, 7'd2);
        check("R1 rx setup a", alloc_result, 8'h00);
        do_cmd(3'd1, 7'd3);
        check("R1 rx setup b", alloc_result, 8'h02);
        rx_in(7'd2);
        rx_in(7'd0);
        check("R6 not empty", rx_empty, 1'b0);
        check("R6 head oldest", rx_head_pnum, 7'd2);
        do_cmd(3'd3, 7'd0);
        check("R7 release pops", rx_head_pnum, 7'd0);
        do_cmd(3'd1, 7'd3);
        check("R7 release freed pages", alloc_result, 8'h02);
        do_cmd(3'd3, 7'd0);
        check("R6 empty after releases", rx_empty, 1'b1);
        do_cmd(3'd3, 7'd0);
        check("R7 release on empty", rx_empty, 1'b1);
        do_cmd(3'd1, 7'd3);
        check("R7 first fit after release", alloc_result, 8'h05);
        do_cmd(3'd1, 7'd2);
        check("R7 head packet pages freed", alloc_result, 8'h00);

        // R8: transmit queue order
        do_cmd(3'd5, 7'd5);
        do_cmd(3'd5, 7'd9);
        check("R8 valid", tx_req_valid, 1'b1);
        check("R8 head first", tx_req_pnum, 7'd5);
        take_pulse();
        check("R8 head second", tx_req_pnum, 7'd9);
        take_pulse();
        check("R8 drained", tx_req_valid, 1'b0);

        // R9: finished queue and transmit interrupt
        tx_done(7'h11);
        check("R9 irq set", irq_status[1], 1'b1);
        check("R9 not empty", txd_empty, 1'b0);
        check("R9 head", txd_pnum, 7'h11);
        tx_done(7'h22);
        txd_pop_pulse();
        check("R9 second", txd_pnum, 7'h22);
        txd_pop_pulse();
        check("R9 drained", txd_empty, 1'b1);
        ack(2'b10);
        check("R9 ack clears", irq_status[1], 1'b0);

        // R5: reset command with everything occupied
        rx_in(7'd3);
        do_cmd(3'd5, 7'd4);
        tx_done(7'd6);
        do_cmd(3'd1, 7'd7);
        do_cmd(3'd2, 7'd0);
        check("R5 cmd result", alloc_result, 8'h80);
        check("R5 cmd irq", irq_status, 2'b00);
        check("R5 cmd rx_empty", rx_empty, 1'b1);
        check("R5 cmd txd_empty", txd_empty, 1'b1);
        check("R5 cmd tx queue", tx_req_valid, 1'b0);
        do_cmd(3'd1, 7'd7);
        check("R5 pages free a", alloc_result, 8'h00);
        do_cmd(3'd1, 7'd7);
        check("R5 pages free b", alloc_result, 8'h07);
        do_cmd(3'd1, 7'd3);
        check("R2 run past end", alloc_result, 8'h80);

        finish_run();
    end

endmodule